// File: doc/BRIEF.md
# Dual-Field Modular Adder-Subtractor

This block adds or subtracts two operands in one of three arithmetic modes. In polynomial mode it adds two polynomials over GF(2), which is a carry-free bitwise exclusive-OR. In plain binary mode it is an ordinary wrapping adder or subtractor of width 2·DIG_W + log2(LANES). In modular mode it adds or subtracts two residues and brings the result back into the range of a channel modulus. It serves as the accumulate stage of a residue-arithmetic multiply-accumulate channel. That channel switches between integer and polynomial fields and between conversion and in-channel arithmetic.

Two selects pick the mode. `fsel` chooses the field: 0 selects polynomials and 1 selects integers. `conv_mode` chooses between plain and modular arithmetic within the integer field. The datapath is built from two carry-lookahead adders. Each has three levels of 4-bit lookahead groups, and their carries can be forced to zero. The first adder produces the raw sum or difference. The second adds or subtracts the modulus to correct the raw value. A parameter places a register on the result.

Top module: `dual_field_addsub`

## Requirements
- R1: With fsel=0 the result is op_a XOR op_b, whatever the values of sub, conv_mode and modulus.
- R2: With fsel=1, conv_mode=0, sub=0 the result is (op_a + op_b) mod 2^W, where W = 2·DIG_W + log2(LANES). The modulus has no effect.
- R3: With fsel=1, conv_mode=0, sub=1 the result is (op_a − op_b) mod 2^W. The modulus has no effect.
- R4: With fsel=1, conv_mode=1, sub=0 and both operands below the modulus, the result is (op_a + op_b) mod modulus. This holds also when op_a + op_b exceeds 2^W − 1.
- R5: With fsel=1, conv_mode=1, sub=1 and both operands below the modulus, the result is (op_a − op_b) mod modulus.
- R6: In modular mode with both operands below the modulus, the result is always below the modulus.
- R7: With REG_OUT=1 the result appears on the clock edge after the inputs are applied, and it holds until that edge. While rst_n is low, a clock edge clears the result to zero.
- R8: In modular mode a sum equal to the modulus gives zero, and subtracting equal operands gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Synchronous active-low reset |
| fsel | input | 1 | Field select: 0 polynomial over GF(2), 1 integer |
| conv_mode | input | 1 | Integer mode: 0 plain binary, 1 modular |
| sub | input | 1 | 0 add, 1 subtract (ignored when fsel=0) |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| modulus | input | W | Channel modulus for modular mode |
| result | output | W | Sum, difference or GF(2) sum |

## Verification
The hardest case to reach is a modular addition whose raw sum carries out of the W-bit adder. Only a modulus close to 2^W lets two in-range operands overflow, and a uniformly drawn modulus seldom comes close. The stimulus therefore forces the top two modulus bits high in half of the random modular cases. It also applies a directed case with the largest modulus and both operands one below it. Further directed cases reach the two exact-zero boundaries, and one case confirms that the output holds its previous value until the clock edge.

// File: rtl/dfas_pkg.sv
// Shared constants and mode decoding for the dual-field adder-subtractor.
// Assumes the lookahead tree is always three levels of 4-wide groups.
package dfas_pkg;
    localparam int GRP    = 4;
    localparam int LEVELS = 3;
    localparam int MAX_W  = GRP ** LEVELS;

    typedef enum logic [1:0] {
        MODE_POLY  = 2'd0,
        MODE_PLAIN = 2'd1,
        MODE_MOD   = 2'd2
    } dfas_mode_e;

    // Map the field select and conversion select onto one arithmetic mode.
    function automatic dfas_mode_e decode_mode(input logic fsel, input logic conv);
        if (!fsel)
            return MODE_POLY;
        else if (conv)
            return MODE_MOD;
        else
            return MODE_PLAIN;
    endfunction
endpackage

// File: rtl/dfas_lcg.sv
// Four-wide lookahead carry generator. It takes transfer and generate terms
// and a carry in. It gives the carry into each position and the group's
// transfer and generate terms. Purely combinational.
module dfas_lcg (
    input  logic [3:0] t_in,
    input  logic [3:0] g_in,
    input  logic       c_in,
    output logic [3:0] c_out,
    output logic       t_grp,
    output logic       g_grp
);
    // Flat two-level carry equations for the four positions.
    always_comb begin
        c_out[0] = c_in;
        c_out[1] = g_in[0] | (t_in[0] & c_in);
        c_out[2] = g_in[1] | (t_in[1] & g_in[0]) | (t_in[1] & t_in[0] & c_in);
        c_out[3] = g_in[2] | (t_in[2] & g_in[1]) | (t_in[2] & t_in[1] & g_in[0])
                 | (t_in[2] & t_in[1] & t_in[0] & c_in);
    end

    // Group terms passed to the next lookahead level.
    always_comb begin
        t_grp = &t_in;
        g_grp = g_in[3] | (t_in[3] & g_in[2]) | (t_in[3] & t_in[2] & g_in[1])
              | (t_in[3] & t_in[2] & t_in[1] & g_in[0]);
    end
endmodule

// File: rtl/dfas_cla.sv
// W-bit carry-lookahead adder with a carry-kill control. When carry_en is 0
// every generate, transfer and carry-in term is forced low, so the sum
// becomes a ^ b. Operands are padded to MAX_W for a three-level tree.
// Assumes W <= MAX_W.
module dfas_cla #(
    parameter int W = 18
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         carry_en,
    output logic [W-1:0] sum,
    output logic         cout
);
    import dfas_pkg::*;

    localparam int PW = MAX_W;
    localparam int N1 = PW / GRP;
    localparam int N2 = N1 / GRP;

    logic [PW-1:0] t_b, g_b;
    logic [W-1:0]  p_b;
    logic          cin_k;
    logic [PW:0]   cb;
    logic [N1-1:0] t1, g1, cg1;
    logic [N2-1:0] t2, g2, cg2;
    logic          t3, g3;

    // Per-bit half-sum, generate and transfer terms, gated by the kill control.
    always_comb begin
        t_b   = '0;
        g_b   = '0;
        p_b   = a ^ b;
        cin_k = cin & carry_en;
        t_b[W-1:0] = (a | b) & {W{carry_en}};
        g_b[W-1:0] = (a & b) & {W{carry_en}};
    end

    for (genvar k = 0; k < N1; k++) begin : g_lvl1
        dfas_lcg u_lcg (
            .t_in  (t_b[GRP*k +: GRP]),
            .g_in  (g_b[GRP*k +: GRP]),
            .c_in  (cg1[k]),
            .c_out (cb[GRP*k +: GRP]),
            .t_grp (t1[k]),
            .g_grp (g1[k])
        );
    end

    for (genvar j = 0; j < N2; j++) begin : g_lvl2
        dfas_lcg u_lcg (
            .t_in  (t1[GRP*j +: GRP]),
            .g_in  (g1[GRP*j +: GRP]),
            .c_in  (cg2[j]),
            .c_out (cg1[GRP*j +: GRP]),
            .t_grp (t2[j]),
            .g_grp (g2[j])
        );
    end

    dfas_lcg u_lvl3 (
        .t_in  (t2),
        .g_in  (g2),
        .c_in  (cin_k),
        .c_out (cg2),
        .t_grp (t3),
        .g_grp (g3)
    );

    // Carry out of the whole padded tree.
    assign cb[PW] = g3 | (t3 & cin_k);

    // Sum bits and the carry out of the top used position.
    assign sum  = p_b ^ cb[W-1:0];
    assign cout = cb[W];

    if (W < PW) begin : g_pad
        logic pad_unused;
        assign pad_unused = ^cb[PW:W+1];
    end
endmodule

// File: rtl/dfas_pick.sv
// Chooses between the raw value and the corrected value. Modular add takes
// the value minus the modulus unless that borrows; the raw 33rd-style carry
// counts as "no borrow". Modular subtract adds the modulus back when the raw
// difference borrowed. Other modes pass the raw value through.
module dfas_pick #(
    parameter int W = 18
) (
    input  dfas_pkg::dfas_mode_e mode,
    input  logic                 sub,
    input  logic [W-1:0]         raw,
    input  logic                 raw_co,
    input  logic [W-1:0]         fix,
    input  logic                 fix_co,
    output logic [W-1:0]         res
);
    import dfas_pkg::*;

    logic use_fix;

    // Decide whether the modulus correction applies.
    always_comb begin
        if (sub)
            use_fix = ~raw_co;
        else
            use_fix = raw_co | fix_co;
    end

    // Final selection by mode.
    always_comb begin
        if (mode == MODE_MOD && use_fix)
            res = fix;
        else
            res = raw;
    end
endmodule

// File: rtl/dual_field_addsub.sv
// Dual-field adder-subtractor. Its modes are GF(2) polynomial addition,
// wrapping binary add or subtract, and add or subtract modulo a channel
// modulus. In modular mode both operands are assumed below the modulus.
// With REG_OUT=1 the result is registered with a synchronous active-low reset.
module dual_field_addsub #(
    parameter int DIG_W   = 8,
    parameter int LANES   = 4,
    parameter bit REG_OUT = 1'b1,
    localparam int W      = 2 * DIG_W + $clog2(LANES)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fsel,
    input  logic         conv_mode,
    input  logic         sub,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] result
);
    import dfas_pkg::*;

    dfas_mode_e  mode;
    logic        int_sub;
    logic [W-1:0] b_eff, m_eff;
    logic [W-1:0] raw_s, fix_s, res_comb;
    logic        raw_co, fix_co;

    // Operand conditioning for both adders.
    always_comb begin
        mode    = decode_mode(fsel, conv_mode);
        int_sub = sub & fsel;
        b_eff   = op_b ^ {W{int_sub}};
        m_eff   = sub ? modulus : ~modulus;
    end

    dfas_cla #(.W(W)) u_main (
        .a        (op_a),
        .b        (b_eff),
        .cin      (int_sub),
        .carry_en (fsel),
        .sum      (raw_s),
        .cout     (raw_co)
    );

    dfas_cla #(.W(W)) u_fix (
        .a        (raw_s),
        .b        (m_eff),
        .cin      (~sub),
        .carry_en (1'b1),
        .sum      (fix_s),
        .cout     (fix_co)
    );

    dfas_pick #(.W(W)) u_pick (
        .mode   (mode),
        .sub    (sub),
        .raw    (raw_s),
        .raw_co (raw_co),
        .fix    (fix_s),
        .fix_co (fix_co),
        .res    (res_comb)
    );

    if (REG_OUT) begin : g_reg
        // Result register, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                result <= '0;
            else
                result <= res_comb;
        end
    end else begin : g_comb
        assign result = res_comb;
    end
endmodule

// File: rtl/dual_field_addsub_chk.sv
// Property checker for the dual-field adder-subtractor, bound to its top.
module dual_field_addsub_chk #(
    parameter int W       = 18,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fsel,
    input logic         conv_mode,
    input logic         sub,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] modulus,
    input logic [W-1:0] res_comb,
    input logic [W-1:0] result
);
    logic [W:0] wa, wb, wm;
    logic       in_range;

    // Widened operands for reference arithmetic.
    always_comb begin
        wa       = {1'b0, op_a};
        wb       = {1'b0, op_b};
        wm       = {1'b0, modulus};
        in_range = (op_a < modulus) && (op_b < modulus);
    end

    a_r1_poly_xor: assert property (@(posedge clk) disable iff (!rst_n)
        !fsel |-> res_comb == (op_a ^ op_b));

    a_r2_plain_add: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel && !conv_mode && !sub) |-> res_comb == W'(wa + wb));

    a_r3_plain_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel && !conv_mode && sub) |-> res_comb == W'(wa - wb));

    a_r4_mod_add: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel && conv_mode && !sub && in_range) |-> {1'b0, res_comb} == (wa + wb) % wm);

    a_r5_mod_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel && conv_mode && sub && in_range) |-> {1'b0, res_comb} == (wa + wm - wb) % wm);

    a_r6_mod_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fsel && conv_mode && in_range) |-> res_comb < modulus);

    a_r7_reset_clear: assert property (@(posedge clk)
        (REG_OUT && !rst_n) |=> result == '0);
endmodule

bind dual_field_addsub dual_field_addsub_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsel      (fsel),
    .conv_mode (conv_mode),
    .sub       (sub),
    .op_a      (op_a),
    .op_b      (op_b),
    .modulus   (modulus),
    .res_comb  (res_comb),
    .result    (result)
);

// File: tb/dual_field_addsub_test.sv
`timescale 1ns/1ps
module dual_field_addsub_test;
    localparam int DIG_W = 8;
    localparam int LANES = 4;
    localparam int W     = 2 * DIG_W + $clog2(LANES);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fsel = 1'b0, conv_mode = 1'b0, sub = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, modulus = '0;
    logic [W-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dual_field_addsub #(.DIG_W(DIG_W), .LANES(LANES), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .fsel(fsel), .conv_mode(conv_mode), .sub(sub),
        .op_a(op_a), .op_b(op_b), .modulus(modulus), .result(result)
    );

    // Reference model built from the requirements.
    function automatic logic [W-1:0] model(input logic f, input logic c, input logic s,
                                           input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] m);
        logic [W:0] wa, wb, wm;
        wa = {1'b0, a};
        wb = {1'b0, b};
        wm = {1'b0, m};
        if (!f) return a ^ b;
        if (!c) return s ? W'(wa - wb) : W'(wa + wb);
        if (s)  return W'((wa + wm - wb) % wm);
        return W'((wa + wb) % wm);
    endfunction

    task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Apply one operation, wait for the register edge, then compare.
    task automatic run(input logic f, input logic c, input logic s,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] m, input string req);
        logic [W-1:0] exp;
        @(negedge clk);
        fsel = f; conv_mode = c; sub = s; op_a = a; op_b = b; modulus = m;
        @(posedge clk);
        #1;
        exp = model(f, c, s, a, b, m);
        check(result, exp, req);
        if (f && c && a < m && b < m)
            check(W'(result < m), W'(1), "R6 below modulus");
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [W-1:0] mx, prev;
        void'($urandom(32'd20240611));
        mx = {W{1'b1}};

        // R7: reset clears the register even with live inputs.
        fsel = 1'b1; op_a = 18'h155; op_b = 18'h2AA; modulus = 18'h3FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result, '0, "R7 reset value");
        rst_n = 1'b1;

        // R1: polynomial mode ignores sub, conv_mode and modulus.
        run(1'b0, 1'b1, 1'b1, 18'h3C0F3, 18'h0FFF0, 18'h00007, "R1 poly xor");
        run(1'b0, 1'b0, 1'b0, mx, mx, 18'h0, "R1 poly self cancel");
        // R2 / R3: wrapping plain arithmetic, modulus has no effect.
        run(1'b1, 1'b0, 1'b0, mx, 18'h2, 18'h5, "R2 plain add wrap");
        run(1'b1, 1'b0, 1'b1, 18'h1, 18'h3, 18'h5, "R3 plain sub wrap");
        // R4: carry out of the raw sum with the largest modulus.
        run(1'b1, 1'b1, 1'b0, mx - 18'h1, mx - 18'h1, mx, "R4 mod add overflow");
        run(1'b1, 1'b1, 1'b0, 18'h00010, 18'h00020, 18'h00100, "R4 mod add no wrap");
        // R5: borrow corrected by adding the modulus back.
        run(1'b1, 1'b1, 1'b1, 18'h00003, 18'h00050, 18'h00061, "R5 mod sub borrow");
        // R8: exact-zero boundaries.
        run(1'b1, 1'b1, 1'b0, 18'h00040, 18'h00021, 18'h00061, "R8 sum equals modulus");
        run(1'b1, 1'b1, 1'b1, 18'h1234, 18'h1234, 18'h2000, "R8 equal operands");

        // R7: output holds until the next edge after an input change.
        prev = result;
        @(negedge clk);
        fsel = 1'b0; op_a = 18'h3FFFF; op_b = 18'h00000;
        #1;
        check(result, prev, "R7 holds before edge");
        @(posedge clk);
        #1;
        check(result, 18'h3FFFF, "R7 updates after edge");

        // Random sweep over every mode.
        for (int i = 0; i < 1200; i++) begin
            logic f, c, s;
            logic [W-1:0] a, b, m;
            f = 1'($urandom); c = 1'($urandom); s = 1'($urandom);
            a = W'($urandom); b = W'($urandom); m = W'($urandom);
            if (f && c) begin
                if (i % 2 == 0) m[W-1:W-2] = 2'b11;
                if (m == '0) m = 18'h1;
                a = W'($urandom % m);
                b = W'($urandom % m);
            end
            run(f, c, s, a, b, m, !f ? "R1 random" : !c ? (s ? "R3 random" : "R2 random")
                                 : (s ? "R5 random" : "R4 random"));
        end

        done = 1'b1;
        finish_up();
    end
endmodule